// File: doc/BRIEF.md
# Memory Region Read-Back Checker

This block verifies a region of memory that an earlier pattern-writing pass filled. It walks the region from a start address, issues one read command per word on a read port with 32-bit addresses and 32-bit data, and compares every returned word with the value the pattern source yields for that word's position in the run. Each word that differs increments a saturating error counter. Software or a test sequencer reads the counter once the run has finished.

The expected value depends only on the word's index within the run, never on its address. As a result, a region that was written with a different base than the one being checked shows mismatches. Checking it again with the base that was used for the write gives a clean result.

Read commands and returning data are handled independently, so the memory may accept commands ahead of returning data and may stall either side. The expected-value source advances only when a data word is taken. The run is reported finished only after the last word has come back.

Top module: `rbk_checker`

## Requirements
- R1: After rst_n is low, or after a cycle with `clr` high, `done` is 0, `errors` is 0, `rd_cmd_valid` is 0 and `rd_dat_ready` is 0.
- R2: A run started with base B and length L issues exactly L read commands with addresses B, B+1, …, B+L-1 (modulo 2^32) in that order. Each address is held stable while `rd_cmd_ready` is low.
- R3: The k-th data word accepted in a run (k counted from 0) is expected to equal k modulo 2^32 with the default pattern (USE_LFSR=0). Reading back a region that holds those values gives zero new errors.
- R4: Each accepted data word that differs from its expected value adds exactly one to `errors`. A region whose last 4 words hold 0..3 where 60..63 are expected adds 4.
- R5: The expected-value source advances only when a data word is accepted, so stalls on commands or on data produce no false errors.
- R6: `done` becomes 1 only in the cycle after the L-th data word has been accepted, not when the last command has been sent. It stays 1 until the next accepted start or `clr`.
- R7: `errors` saturates at 2^ERR_W-1 instead of wrapping.
- R8: A `start` pulse while a run is in progress is ignored.
- R9: A run with length 0 issues no command and sets `done` in the cycle after `start`.
- R10: `start` does not clear `errors`; only `clr` or rst_n does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of run state and error counter |
| start | input | 1 | One-cycle pulse that begins a run |
| base | input | 32 | First word address of the run |
| length | input | 32 | Number of words to check |
| done | output | 1 | Run finished, all data returned |
| errors | output | ERR_W | Saturating mismatch count |
| rd_cmd_valid | output | 1 | Read command valid |
| rd_cmd_ready | input | 1 | Read command accepted |
| rd_cmd_addr | output | 32 | Read command word address |
| rd_dat_valid | input | 1 | Returned data valid |
| rd_dat_ready | output | 1 | Checker takes returned data |
| rd_dat | input | 32 | Returned data word |

## Verification
The assertions assume that the memory side returns a data word only for a command it has already accepted, and returns data in command order. The bench responder therefore queues each accepted address and returns data only from that non-empty queue, one cycle or more after the command. It inserts gaps on both the command and data sides without breaking that ordering. The bench also pulses `clr` only while no run is in progress, so that no stale data is left in flight.

// File: rtl/rbk_pkg.sv
package rbk_pkg;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int LEN_W  = 32;
  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] word_t;
  typedef logic [LEN_W-1:0]  len_t;
endpackage

// File: rtl/rbk_pattern.sv
module rbk_pattern
  import rbk_pkg::*;
#(
  parameter bit          USE_LFSR = 1'b0,
  parameter logic [31:0] TAPS     = 32'h8020_0003,
  parameter logic [31:0] SEED     = 32'h0000_0001
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  restart,
  input  logic  advance,
  output word_t expected
);
  word_t state_q, state_d, step;

  generate
    if (USE_LFSR) begin : g_lfsr
      always_comb step = {state_q[DATA_W-2:0], 1'b0} ^ (state_q[DATA_W-1] ? TAPS : '0);
    end else begin : g_count
      always_comb step = state_q + word_t'(1);
    end
  endgenerate

  always_comb begin
    state_d = state_q;
    if (restart)      state_d = USE_LFSR ? SEED : '0;
    else if (advance) state_d = step;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) state_q <= USE_LFSR ? SEED : '0;
    else        state_q <= state_d;

  assign expected = state_q;

  // R5: the value moves only on an accepted data word or a restart
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && !advance) |=> $stable(expected));
endmodule

// File: rtl/rbk_issue.sv
module rbk_issue
  import rbk_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clr,
  input  logic  launch,
  input  logic  busy,
  input  addr_t base,
  input  len_t  len,
  input  logic  cmd_ready,
  output logic  cmd_valid,
  output addr_t cmd_addr,
  output len_t  sent
);
  addr_t addr_q, addr_d;
  len_t  sent_q, sent_d;
  logic  fire;

  assign cmd_valid = busy && (sent_q != len);
  assign fire      = cmd_valid && cmd_ready;

  always_comb begin
    addr_d = addr_q;
    sent_d = sent_q;
    if (clr) begin
      addr_d = '0;
      sent_d = '0;
    end else if (launch) begin
      addr_d = base;
      sent_d = '0;
    end else if (fire) begin
      addr_d = addr_q + addr_t'(1);
      sent_d = sent_q + len_t'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      addr_q <= '0;
      sent_q <= '0;
    end else begin
      addr_q <= addr_d;
      sent_q <= sent_d;
    end

  assign cmd_addr = addr_q;
  assign sent     = sent_q;

  // R2: a stalled command keeps its address
  assert_cmd_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready && !clr) |=> (cmd_valid && $stable(cmd_addr)));
  // R2: an accepted command is followed by the next address
  assert_cmd_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !clr) |=> (cmd_addr == $past(cmd_addr) + addr_t'(1)));
endmodule

// File: rtl/rbk_tally.sv
module rbk_tally #(
  parameter int ERR_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             hit,
  output logic [ERR_W-1:0] count
);
  logic [ERR_W-1:0] cnt_q, cnt_d;
  logic             full;

  assign full = &cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)              cnt_d = '0;
    else if (hit && !full) cnt_d = cnt_q + {{(ERR_W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;

  assign count = cnt_q;

  assert_err_sat_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((&count) && !clr) |=> (&count));
  assert_err_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (count == $past(count) || count == $past(count) + {{(ERR_W-1){1'b0}}, 1'b1}));
  assert_err_clr_R1: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0));
endmodule

// File: rtl/rbk_checker.sv
module rbk_checker
  import rbk_pkg::*;
#(
  parameter int ERR_W    = 32,
  parameter bit USE_LFSR = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             start,
  input  logic [31:0]      base,
  input  logic [31:0]      length,
  output logic             done,
  output logic [ERR_W-1:0] errors,
  output logic             rd_cmd_valid,
  input  logic             rd_cmd_ready,
  output logic [31:0]      rd_cmd_addr,
  input  logic             rd_dat_valid,
  output logic             rd_dat_ready,
  input  logic [31:0]      rd_dat
);
  logic  busy_q, busy_d, done_q, done_d;
  len_t  len_q, len_d, got_q, got_d, sent;
  logic  launch, take, last;
  word_t expected;

  assign launch       = start && !busy_q && !clr;
  assign rd_dat_ready = busy_q;
  assign take         = rd_dat_valid && busy_q;
  assign last         = (got_q == len_q - len_t'(1));

  always_comb begin
    busy_d = busy_q;
    done_d = done_q;
    len_d  = len_q;
    got_d  = got_q;
    if (clr) begin
      busy_d = 1'b0;
      done_d = 1'b0;
      got_d  = '0;
    end else if (launch) begin
      len_d  = length;
      got_d  = '0;
      busy_d = (length != '0);
      done_d = (length == '0);
    end else if (take) begin
      got_d = got_q + len_t'(1);
      if (last) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      len_q  <= '0;
      got_q  <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      len_q  <= len_d;
      got_q  <= got_d;
    end

  assign done = done_q;

  rbk_issue u_issue (
    .clk(clk), .rst_n(rst_n), .clr(clr), .launch(launch), .busy(busy_q),
    .base(base), .len(len_q), .cmd_ready(rd_cmd_ready),
    .cmd_valid(rd_cmd_valid), .cmd_addr(rd_cmd_addr), .sent(sent)
  );

  rbk_pattern #(.USE_LFSR(USE_LFSR)) u_pat (
    .clk(clk), .rst_n(rst_n), .restart(launch || clr), .advance(take),
    .expected(expected)
  );

  rbk_tally #(.ERR_W(ERR_W)) u_tally (
    .clk(clk), .rst_n(rst_n), .clr(clr), .hit(take && (rd_dat != expected)),
    .count(errors)
  );

  // R6: done rises only once every word has come back
  assert_done_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(done) && len_q != '0) |-> (got_q == len_q && sent == len_q));
  // R9: nothing is requested outside a run
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> (!rd_cmd_valid && !rd_dat_ready));
  // R5: data is only taken for a command already sent (input assumption)
  assert_no_orphan_R5: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (got_q < sent));
  // R8: a run's length is not replaced while it is in progress
  assert_len_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !clr) |=> $stable(len_q));
endmodule

// File: tb/sim_rbk_checker.sv
module sim_rbk_checker;
  localparam int EW = 8;
  logic clk = 1'b0, rst_n = 1'b0, clr = 1'b0, start = 1'b0;
  logic [31:0] base = '0, length = '0;
  logic done, rd_cmd_valid, rd_dat_ready;
  logic rd_cmd_ready = 1'b0, rd_dat_valid = 1'b0;
  logic [31:0] rd_cmd_addr, rd_dat = '0;
  logic [EW-1:0] errors;

  int checks = 0, fails = 0;
  logic [31:0] mem [0:255];
  logic [31:0] q [0:1023];
  int wp = 0, rp = 0, cyc = 0, cmd_seen = 0, addr_bad = 0;
  logic [31:0] exp_addr = '0, addr_f = '0;
  logic cmd_fire = 1'b0, dat_fire = 1'b0, gate = 1'b1, stall = 1'b0, finished = 1'b0;

  always #2.5 clk = ~clk;

  rbk_checker #(.ERR_W(EW)) u0 (
    .clk(clk), .rst_n(rst_n), .clr(clr), .start(start), .base(base), .length(length),
    .done(done), .errors(errors), .rd_cmd_valid(rd_cmd_valid), .rd_cmd_ready(rd_cmd_ready),
    .rd_cmd_addr(rd_cmd_addr), .rd_dat_valid(rd_dat_valid), .rd_dat_ready(rd_dat_ready),
    .rd_dat(rd_dat)
  );

  // memory responder: in-order, at least one cycle of latency
  always @(negedge clk) begin
    if (cmd_fire) begin
      q[wp % 1024] = addr_f;
      wp++;
      if (addr_f != exp_addr) addr_bad++;
      exp_addr = exp_addr + 1;
      cmd_seen++;
    end
    if (dat_fire) rp++;
    cyc++;
    rd_cmd_ready = stall ? (cyc % 3 != 0) : 1'b1;
    rd_dat_valid = gate && (wp != rp) && (stall ? (cyc % 4 != 1) : 1'b1);
    rd_dat = mem[q[rp % 1024][7:0]];
    #1;
    cmd_fire = rd_cmd_valid && rd_cmd_ready;
    addr_f   = rd_cmd_addr;
    dat_fire = rd_dat_valid && rd_dat_ready;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic fill(input int b, input int n, input logic [31:0] v0);
    for (int i = 0; i < n; i++) mem[(b + i) % 256] = v0 + 32'(i);
  endtask

  task automatic go(input logic [31:0] b, input logic [31:0] n);
    @(negedge clk);
    base = b; length = n; start = 1'b1; exp_addr = b; cmd_seen = 0; addr_bad = 0;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    int k = 0;
    while (!done && k < 5000) begin @(negedge clk); k++; end
    #2;
  endtask

  task automatic pulse_clr();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    #2;
  endtask

  task automatic t_reset();
    #2;
    check("R1 done", 32'(done), 0);
    check("R1 errors", 32'(errors), 0);
    check("R1 cmd_valid", 32'(rd_cmd_valid), 0);
    check("R1 dat_ready", 32'(rd_dat_ready), 0);
  endtask

  task automatic t_match();
    fill(16, 64, 0);
    go(16, 64); wait_done();
    check("R3 clean readback", 32'(errors), 0);
    check("R2 cmd count", cmd_seen, 64);
    check("R2 addr order", addr_bad, 0);
  endtask

  task automatic t_overwrite();
    fill(76, 64, 0);
    go(16, 64); wait_done();
    check("R4 four mismatches", 32'(errors), 4);
    go(76, 64); wait_done();
    check("R10 start keeps errors", 32'(errors), 4);
    pulse_clr();
    check("R1 clr errors", 32'(errors), 0);
    check("R1 clr done", 32'(done), 0);
  endtask

  task automatic t_stall();
    stall = 1'b1;
    go(76, 64); wait_done();
    check("R5 stalls no false errors", 32'(errors), 0);
    check("R2 stalled addr order", addr_bad, 0);
    stall = 1'b0;
  endtask

  task automatic t_hold();
    fill(0, 8, 0);
    gate = 1'b0;
    go(0, 8);
    repeat (20) @(negedge clk);
    #2;
    check("R6 all commands sent", cmd_seen, 8);
    check("R6 no done before data", 32'(done), 0);
    @(negedge clk); base = 100; length = 3; start = 1'b1;
    @(negedge clk); start = 1'b0;
    gate = 1'b1;
    wait_done();
    check("R8 start ignored cmds", cmd_seen, 8);
    check("R8 start ignored errors", 32'(errors), 0);
    check("R6 done after data", 32'(done), 1);
  endtask

  task automatic t_zero();
    go(5, 0);
    #2;
    check("R9 done after start", 32'(done), 1);
    check("R9 no commands", cmd_seen, 0);
  endtask

  task automatic t_sat();
    fill(0, 256, 32'hDEAD_0000);
    go(0, 300); wait_done();
    check("R7 saturate", 32'(errors), 255);
    pulse_clr();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_match();
    t_overwrite();
    t_stall();
    t_hold();
    t_zero();
    t_sat();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, fails);
      $finish;
    end
  end
endmodule